// File: doc/BRIEF.md
# Charge Sequence Centroid Extractor

This block consumes digitised charge samples from one readout pad at a time. Each accepted beat carries a pad number, a time bin and an ADC value. The block groups consecutive nonzero samples along the time axis into sequences. For each sequence it emits a single record that holds the pad, the first time bin, the sample count, the summed charge and a charge-weighted offset sum. A downstream stage divides the weighted sum by the charge and adds the start time to obtain the charge-weighted mean time.

Each sample is weighted by its distance from the first sample of its sequence, not by its absolute time bin. Because a sequence is never longer than ten samples, the weight stays below ten and the multiplier stays small. When the deconvolution input is high, a run is also cut where the charge falls and then rises again. This separates two overlapping pulses on the same pad.

A separate end-of-pad marker beat closes whatever sequence is open. The record leaves through a valid/ready pair. While a record waits to be taken, the input is stalled.

Top module: `seq_centroid`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A run of nonzero samples on one pad produces one record. The record holds that pad, the time bin of the run's first sample, the number of samples, and the sum of their ADC values.
- R3: `out_wsum` equals the sum of k × adc_k, where k = 0 for the first sample of the sequence and rises by one per sample.
- R4: An accepted sample with ADC value 0 closes the open sequence. Zero samples while no sequence is open produce no record.
- R5: A nonzero sample whose pad differs from the open sequence's pad closes that sequence. The new sample then begins a fresh sequence.
- R6: A beat with `in_eop` = 1 closes the open sequence, and its pad, time and ADC fields are ignored. With nothing open, such a beat produces no record.
- R7: A sequence holds at most 10 samples. A nonzero sample on the same pad that arrives when 10 are held closes the sequence and begins a new one.
- R8: With `decon_en` = 1, a nonzero sample that is greater than its predecessor closes the sequence if the charge fell since the last rise within the sequence. The rising sample then begins a new sequence. Equal samples leave the fall state unchanged.
- R9: With `decon_en` = 0, no fall/rise pattern splits a sequence.
- R10: `in_ready` is 0 while `out_valid` is 1. A record stays valid and unchanged until `out_ready` is 1 at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| decon_en | input | 1 | Enables splitting at a charge minimum |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_eop | input | 1 | Beat is an end-of-pad marker |
| in_pad | input | 8 | Pad number |
| in_time | input | 10 | Time bin |
| in_adc | input | 10 | Charge sample |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record |
| out_pad | output | 8 | Pad of the sequence |
| out_start | output | 10 | Time bin of the first sample |
| out_len | output | 4 | Sample count, 1 to 10 |
| out_charge | output | 14 | Summed charge |
| out_wsum | output | 16 | Offset-weighted charge sum |

## Verification
Some properties hold on every cycle and are checked by assertions. A held record does not change while it is stalled. The length always lies between 1 and 10. The charge is at least the length, and the weighted sum never exceeds (length−1) times the charge. An end-of-pad marker with no open sequence never raises a record. The exact points where runs are cut only show up in the bench's scenarios, where a sample-queue model predicts each record. These cut points are zeros, pad changes, markers, the ten-sample limit, and fall-then-rise with deconvolution on or off. The scenarios also check the record contents under random backpressure.

// File: rtl/seq_centroid.sv
module seq_centroid #(
  parameter int PAD_W   = 8,
  parameter int TIME_W  = 10,
  parameter int ADC_W   = 10,
  parameter int MAX_LEN = 10,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int CHG_W  = ADC_W + LEN_W,
  localparam int WS_W   = ADC_W + $clog2(MAX_LEN * (MAX_LEN - 1) / 2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decon_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_eop,
  input  logic [PAD_W-1:0]  in_pad,
  input  logic [TIME_W-1:0] in_time,
  input  logic [ADC_W-1:0]  in_adc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PAD_W-1:0]  out_pad,
  output logic [TIME_W-1:0] out_start,
  output logic [LEN_W-1:0]  out_len,
  output logic [CHG_W-1:0]  out_charge,
  output logic [WS_W-1:0]   out_wsum
);

  logic              open_q, fell_q;
  logic [PAD_W-1:0]  pad_q;
  logic [TIME_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q;
  logic [CHG_W-1:0]  chg_q;
  logic [WS_W-1:0]   ws_q;
  logic [ADC_W-1:0]  prev_q;

  assign in_ready = !out_valid;

  wire take   = in_valid && in_ready;
  wire smp    = take && !in_eop && (in_adc != '0);
  wire same   = open_q && (in_pad == pad_q);
  wire rise   = in_adc > prev_q;
  wire fall   = in_adc < prev_q;
  wire full   = len_q == LEN_W'(MAX_LEN);
  wire split  = (decon_en && fell_q && rise) || full;
  wire extend = smp && same && !split;
  wire fresh  = smp && !extend;
  wire close  = take && open_q && !extend;

  wire [WS_W-1:0] prod = WS_W'(len_q) * WS_W'(in_adc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      fell_q  <= 1'b0;
      pad_q   <= '0;
      start_q <= '0;
      len_q   <= '0;
      chg_q   <= '0;
      ws_q    <= '0;
      prev_q  <= '0;
    end else if (extend) begin
      len_q  <= len_q + 1'b1;
      chg_q  <= chg_q + CHG_W'(in_adc);
      ws_q   <= ws_q + prod;
      prev_q <= in_adc;
      fell_q <= fall ? 1'b1 : (rise ? 1'b0 : fell_q);
    end else if (fresh) begin
      open_q  <= 1'b1;
      fell_q  <= 1'b0;
      pad_q   <= in_pad;
      start_q <= in_time;
      len_q   <= LEN_W'(1);
      chg_q   <= CHG_W'(in_adc);
      ws_q    <= '0;
      prev_q  <= in_adc;
    end else if (close) begin
      open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_pad    <= '0;
      out_start  <= '0;
      out_len    <= '0;
      out_charge <= '0;
      out_wsum   <= '0;
    end else if (close) begin
      out_valid  <= 1'b1;
      out_pad    <= pad_q;
      out_start  <= start_q;
      out_len    <= len_q;
      out_charge <= chg_q;
      out_wsum   <= ws_q;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pad) && $stable(out_start)
      && $stable(out_len) && $stable(out_charge) && $stable(out_wsum));

  // R7
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len >= LEN_W'(1) && out_len <= LEN_W'(MAX_LEN));

  // R2
  charge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 32'(out_charge) >= 32'(out_len));

  // R3
  wsum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 32'(out_wsum) <= (32'(out_len) - 32'd1) * 32'(out_charge));

  // R6
  idle_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_eop && !open_q |=> !out_valid);

endmodule

// File: tb/seq_centroid_test.sv
`timescale 1ns/1ps
module seq_centroid_test;
  localparam int MAXL = 10;

  logic clk = 0, rst_n = 0, decon_en = 0;
  logic in_valid = 0, in_eop = 0, out_ready = 1;
  logic [7:0] in_pad = 0;
  logic [9:0] in_time = 0, in_adc = 0;
  logic in_ready, out_valid;
  logic [7:0] out_pad;
  logic [9:0] out_start;
  logic [3:0] out_len;
  logic [13:0] out_charge;
  logic [15:0] out_wsum;

  always #2 clk = ~clk;

  seq_centroid uut (.clk, .rst_n, .decon_en, .in_valid, .in_ready, .in_eop, .in_pad,
    .in_time, .in_adc, .out_valid, .out_ready, .out_pad, .out_start, .out_len,
    .out_charge, .out_wsum);

  int checks = 0, fails = 0;
  string cur_tag = "R2";
  bit bp = 0;

  int e_pad[$], e_start[$], e_len[$], e_chg[$], e_ws[$];
  string e_tag[$];

  int q[$];
  bit m_open = 0;
  int m_pad = 0, m_start = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void emit();
    int c = 0, w = 0;
    foreach (q[i]) begin c += q[i]; w += i * q[i]; end
    e_pad.push_back(m_pad); e_start.push_back(m_start); e_len.push_back(q.size());
    e_chg.push_back(c); e_ws.push_back(w); e_tag.push_back(cur_tag);
  endfunction

  function automatic bit fell_state();
    for (int i = q.size() - 1; i > 0; i--)
      if (q[i] != q[i-1]) return q[i] < q[i-1];
    return 0;
  endfunction

  function automatic void model(bit eop, int pad, int t, int adc);
    if (eop || adc == 0) begin
      if (m_open) emit();
      m_open = 0;
    end else if (m_open && pad == m_pad && q.size() < MAXL
                 && !(decon_en && fell_state() && adc > q[q.size()-1])) begin
      q.push_back(adc);
    end else begin
      if (m_open) emit();
      m_open = 1; m_pad = pad; m_start = t;
      q.delete(); q.push_back(adc);
    end
  endfunction

  task automatic send(bit eop, int pad, int t, int adc);
    in_valid = 1; in_eop = eop; in_pad = 8'(pad); in_time = 10'(t); in_adc = 10'(adc);
    while (!in_ready) @(negedge clk);
    model(eop, pad, t, adc);
    @(negedge clk);
    in_valid = 0; in_eop = 0;
  endtask

  task automatic run(int pad, int t0, int v[$]);
    foreach (v[i]) send(0, pad, t0 + i, v[i]);
  endtask

  task automatic drain();
    int n = 0;
    while ((e_pad.size() != 0 || out_valid) && n < 200) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  bit hv = 0;
  int h_pad, h_start, h_len, h_chg, h_ws;

  always @(negedge clk) if (rst_n) begin
    bit nr;
    nr = bp ? ($urandom % 3 != 0) : 1'b1;
    if (out_valid) check(!in_ready, "R10", "in_ready while record pending", int'(in_ready), 0);
    if (hv) begin
      check(out_valid && out_pad == 8'(h_pad) && out_start == 10'(h_start) && out_len == 4'(h_len)
            && out_charge == 14'(h_chg) && out_wsum == 16'(h_ws), "R10", "held record changed",
            int'(out_charge), h_chg);
    end
    hv = out_valid && !nr;
    h_pad = out_pad; h_start = out_start; h_len = out_len; h_chg = out_charge; h_ws = out_wsum;
    if (out_valid && nr) begin
      if (e_pad.size() == 0) check(0, "R2", "unexpected record len", int'(out_len), 0);
      else begin
        string tg = e_tag.pop_front();
        check(out_pad == 8'(e_pad[0]), tg, "pad", int'(out_pad), e_pad[0]);
        check(out_start == 10'(e_start[0]), tg, "start", int'(out_start), e_start[0]);
        check(out_len == 4'(e_len[0]), tg, "len", int'(out_len), e_len[0]);
        check(out_charge == 14'(e_chg[0]), tg, "charge", int'(out_charge), e_chg[0]);
        check(out_wsum == 16'(e_ws[0]), tg, "wsum", int'(out_wsum), e_ws[0]);
        void'(e_pad.pop_front()); void'(e_start.pop_front()); void'(e_len.pop_front());
        void'(e_chg.pop_front()); void'(e_ws.pop_front());
      end
    end
    out_ready = nr;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WATCHDOG", "timeout", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!out_valid && in_ready, "R1", "reset state valid/ready", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);

    cur_tag = "R2 R3";
    run(1, 100, '{4, 9, 3}); send(0, 1, 103, 0);
    run(2, 300, '{1023, 1023, 1023, 1023}); send(0, 2, 304, 0);
    drain();

    cur_tag = "R4";
    send(0, 3, 0, 0); send(0, 3, 1, 0);
    repeat (3) @(negedge clk);
    check(!out_valid, "R4", "record from idle zeros", int'(out_valid), 0);
    run(3, 2, '{6}); send(0, 3, 3, 0); run(3, 4, '{2, 2}); send(0, 3, 6, 0);
    drain();

    cur_tag = "R5";
    run(5, 10, '{2, 3}); run(6, 12, '{8}); send(1, 0, 0, 0);
    drain();

    cur_tag = "R6";
    send(1, 7, 50, 999);
    repeat (3) @(negedge clk);
    check(!out_valid, "R6", "record from idle marker", int'(out_valid), 0);
    run(7, 0, '{1, 1}); send(1, 7, 2, 500);
    drain();

    cur_tag = "R7";
    run(8, 0, '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13}); send(1, 0, 0, 0);
    drain();

    cur_tag = "R8";
    decon_en = 1;
    run(9, 0, '{3, 5, 2, 4, 1}); send(0, 9, 5, 0);
    run(9, 20, '{6, 2, 2, 7, 3}); send(0, 9, 25, 0);
    run(9, 40, '{1, 2, 3, 3}); send(1, 0, 0, 0);
    drain();

    cur_tag = "R9";
    decon_en = 0;
    run(9, 60, '{3, 5, 2, 4, 1}); send(0, 9, 65, 0);
    drain();

    cur_tag = "R10";
    bp = 1;
    for (int b = 0; b < 400; b++) begin
      int r = $urandom % 16;
      if (b % 50 == 0) decon_en = $urandom % 2;
      if (r == 0) send(1, 0, 0, 0);
      else send(0, ($urandom % 8 == 0) ? 20 + $urandom % 3 : 20, b, (r < 5) ? 0 : $urandom % 1024);
    end
    send(1, 0, 0, 0);
    drain();
    bp = 0;
    repeat (4) @(negedge clk);
    check(e_pad.size() == 0, "R2", "records still expected", e_pad.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule